// File: doc/BRIEF.md
# Game Controller Port Interface (Console Side)

This block sits between a CPU bus and two serial game-controller ports. A CPU write to the first port address stores the low write-data bits in a small output latch; latch bit 0 is the shared strobe line that tells every attached controller to reload its button shift register. A CPU read of a port address produces a low pulse on that port's clock line. The console samples the port's serial data line as the clock falls. The controller shifts on the rising edge that ends the pulse.

Each read loads a read-data register. The register holds the fixed open-bus pattern 0x40 with the sampled serial bit in bit 0. When microphone mode is enabled and the read is from the first port, the microphone input appears in bit 2. A `dma_glitch` input models a DMA cycle that cuts into a controller read. The clock then returns high for one cycle in the middle of the access, and the controller sees an extra shift. The console samples a second time after that shift, so one serial bit is lost.

Each port clock is driven by a four-state sequencer. The states are IDLE, ACCESS, DROP and REDO. In IDLE the clock is high, and in ACCESS the clock is low. DROP is the extra high cycle caused by a glitch, and REDO is the second low cycle that follows it. The transitions are:
- IDLE→ACCESS on an accepted read.
- ACCESS→IDLE on a plain read.
- ACCESS→DROP when a glitch was flagged with the read.
- DROP→REDO, always.
- REDO→IDLE, always.

Top module: `ctrl_port_if`

## Requirements
- R1: A cycle with `cpu_valid`=1, `cpu_rnw`=0 and `cpu_addr`=0x4016 loads `cpu_wdata[2:0]` into `out_latch` on the next clock edge. Bits 7:3 of the write data are ignored. Writes to any other address, including 0x4017, leave `out_latch` unchanged.
- R2: `strobe` always equals `out_latch[0]`.
- R3: A read (`cpu_valid`=1, `cpu_rnw`=1) of 0x4016 addresses port 0, and a read of 0x4017 addresses port 1. If the addressed port is in IDLE, its `port_clk` bit is low for exactly the one cycle after the accepting edge and then returns high. The other port's clock stays high.
- R4: On the edge that accepts a read, `rd_data` loads 0x40 with the addressed port's `port_data` bit in bit 0. That is the value on the line while the clock was still high, before any shift. Bits 7:3 always read 01000 and bit 1 always reads 0.
- R5: `rd_data[2]` equals `mic_in` only when `mic_mode`=1 and the read addresses port 0. Otherwise it is 0.
- R6: A read accepted with `dma_glitch`=1 drives that port's clock low, high, low and then high over four cycles. `rd_data` is reloaded at the second falling edge, so the controller's next bit is returned and the bit in between is lost.
- R7: A read of a port that is not in IDLE is ignored. It causes no extra clock edge and does not change `rd_data`.
- R8: After reset, `out_latch` is 0, `strobe` is low, both `port_clk` bits are high and `rd_data` is 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_valid | input | 1 | Bus access present this cycle |
| cpu_wdata | input | 8 | CPU write data |
| dma_glitch | input | 1 | A DMA cycle interrupts the read accepted in this cycle |
| port_data | input | 2 | Serial data line from each port (bit i = port i) |
| mic_in | input | 1 | Microphone level |
| mic_mode | input | 1 | 1 = report the microphone in bit 2 of port-0 reads |
| rd_data | output | 8 | Read data from the last accepted port read |
| out_latch | output | 3 | Output latch bits |
| strobe | output | 1 | Shared controller reload line |
| port_clk | output | 2 | Clock line for each port, idles high |

## Verification
The bench runs a full serial read-out from a model controller, past the eighth bit into the trailing ones. A design that sampled after the shift rather than before it would return every button one position early. A held strobe must keep returning the first button; a design that ignored the strobe level would walk through the report. The glitch read must return the bit two places on, with the clock waveform low-high-low-high. A second read issued while a port is busy must produce no extra clock edge; a design that accepted it would shift one extra bit and corrupt the next value read. The microphone bit is tried on both ports and in both modes, so a design that leaked it onto port 1 or into normal mode would show bit 2 set.

// File: rtl/ctrl_port_pkg.sv
package ctrl_port_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ACCESS = 2'd1,
        SEQ_DROP   = 2'd2,
        SEQ_REDO   = 2'd3
    } seq_state_t;

    // A state in which the port clock line sits high.
    function automatic logic clk_high_in(input seq_state_t st);
        return (st == SEQ_IDLE) || (st == SEQ_DROP);
    endfunction

endpackage

// File: rtl/ctrl_port_decode.sv
module ctrl_port_decode #(
    parameter int               ADDR_W    = 16,
    parameter int               NUM_PORTS = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4016
) (
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic                 cpu_rnw,
    input  logic                 cpu_valid,
    output logic [NUM_PORTS-1:0] rd_hit,
    output logic                 wr_hit
);

    // The output latch lives at the first port address only.
    assign wr_hit = cpu_valid && !cpu_rnw && (cpu_addr == BASE_ADDR);

    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_port_dec
        localparam logic [ADDR_W-1:0] PORT_ADDR = BASE_ADDR + ADDR_W'(gi);
        assign rd_hit[gi] = cpu_valid && cpu_rnw && (cpu_addr == PORT_ADDR);
    end

endmodule

// File: rtl/ctrl_port_latch.sv
module ctrl_port_latch #(
    parameter int DATA_W  = 8,
    parameter int LATCH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [DATA_W-1:0]  wdata,
    output logic [LATCH_W-1:0] latch_q
);

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:LATCH_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (wr_hit) begin
            latch_q <= wdata[LATCH_W-1:0];
        end
    end

endmodule

// File: rtl/ctrl_port_seq.sv
module ctrl_port_seq
    import ctrl_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_hit,
    input  logic dma_glitch,
    output logic line_clk,
    output logic capture,
    output logic idle
);

    seq_state_t state_q, state_d;
    logic       redo_q, redo_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            redo_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            redo_q  <= redo_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        redo_d  = redo_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (rd_hit) begin
                    state_d = SEQ_ACCESS;
                    redo_d  = dma_glitch;
                end
            end
            SEQ_ACCESS: begin
                state_d = redo_q ? SEQ_DROP : SEQ_IDLE;
                redo_d  = 1'b0;
            end
            SEQ_DROP: state_d = SEQ_REDO;
            SEQ_REDO: state_d = SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    // Outputs: the clock line is registered so that it cannot glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_clk <= 1'b1;
        end else begin
            line_clk <= clk_high_in(state_d);
        end
    end

    // Sample the data line on every edge where the clock line falls.
    assign capture = ((state_q == SEQ_IDLE) && rd_hit) || (state_q == SEQ_DROP);
    assign idle    = (state_q == SEQ_IDLE);

endmodule

// File: rtl/ctrl_port_if.sv
module ctrl_port_if #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter int                NUM_PORTS = 2,
    parameter int                LATCH_W   = 3,
    parameter int                MIC_BIT   = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4016,
    parameter logic [DATA_W-1:0] OPEN_BUS  = 8'h40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic                 cpu_rnw,
    input  logic                 cpu_valid,
    input  logic [DATA_W-1:0]    cpu_wdata,
    input  logic                 dma_glitch,
    input  logic [NUM_PORTS-1:0] port_data,
    input  logic                 mic_in,
    input  logic                 mic_mode,
    output logic [DATA_W-1:0]    rd_data,
    output logic [LATCH_W-1:0]   out_latch,
    output logic                 strobe,
    output logic [NUM_PORTS-1:0] port_clk
);

    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic [NUM_PORTS-1:0] rd_hit;
    logic                 wr_hit;
    logic [NUM_PORTS-1:0] port_capture;
    logic [NUM_PORTS-1:0] port_idle;

    ctrl_port_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_PORTS (NUM_PORTS),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .cpu_addr  (cpu_addr),
        .cpu_rnw   (cpu_rnw),
        .cpu_valid (cpu_valid),
        .rd_hit    (rd_hit),
        .wr_hit    (wr_hit)
    );

    ctrl_port_latch #(
        .DATA_W  (DATA_W),
        .LATCH_W (LATCH_W)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wdata   (cpu_wdata),
        .latch_q (out_latch)
    );

    assign strobe = out_latch[0];

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
        ctrl_port_seq u_seq (
            .clk        (clk),
            .rst_n      (rst_n),
            .rd_hit     (rd_hit[gp]),
            .dma_glitch (dma_glitch),
            .line_clk   (port_clk[gp]),
            .capture    (port_capture[gp]),
            .idle       (port_idle[gp])
        );
    end

    // Pick the capturing port; the lowest index wins if two coincide.
    logic             cap_any;
    logic [IDX_W-1:0] cap_idx;

    always_comb begin
        cap_any = 1'b0;
        cap_idx = '0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (port_capture[i]) begin
                cap_any = 1'b1;
                cap_idx = IDX_W'(i);
            end
        end
    end

    logic [DATA_W-1:0] rd_next;

    always_comb begin
        rd_next    = OPEN_BUS;
        rd_next[0] = port_data[cap_idx];
        if (mic_mode && (cap_idx == '0)) begin
            rd_next[MIC_BIT] = mic_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= OPEN_BUS;
        end else if (cap_any) begin
            rd_data <= rd_next;
        end
    end

endmodule

// File: rtl/ctrl_port_if_chk.sv
module ctrl_port_if_chk #(
    parameter int                DATA_W    = 8,
    parameter int                NUM_PORTS = 2,
    parameter int                LATCH_W   = 3,
    parameter int                MIC_BIT   = 2,
    parameter logic [DATA_W-1:0] OPEN_BUS  = 8'h40
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PORTS-1:0] rd_hit,
    input logic                 wr_hit,
    input logic [NUM_PORTS-1:0] port_idle,
    input logic [NUM_PORTS-1:0] port_clk,
    input logic [LATCH_W-1:0]   out_latch,
    input logic [DATA_W-1:0]    cpu_wdata,
    input logic [DATA_W-1:0]    rd_data
);

    localparam logic [DATA_W-1:0] FIXED_MASK =
        ~(DATA_W'(1) | (DATA_W'(1) << MIC_BIT));

    assert_latch_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (out_latch == $past(cpu_wdata[LATCH_W-1:0])));

    assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(out_latch));

    assert_open_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data & FIXED_MASK) == (OPEN_BUS & FIXED_MASK)));

    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_chk
        assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
            port_idle[gi] |-> port_clk[gi]);

        assert_read_falls_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_hit[gi] && port_idle[gi]) |=> !port_clk[gi]);

        assert_low_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !port_clk[gi] |=> port_clk[gi]);

        assert_busy_no_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!port_idle[gi] && !port_clk[gi]) |=> port_clk[gi]);
    end

    for (genvar gj = 1; gj < NUM_PORTS; gj++) begin : g_mic
        assert_no_mic_other_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_hit[gj] && port_idle[gj] && port_idle[0]) |=> !rd_data[MIC_BIT]);
    end

endmodule

bind ctrl_port_if ctrl_port_if_chk #(
    .DATA_W    (DATA_W),
    .NUM_PORTS (NUM_PORTS),
    .LATCH_W   (LATCH_W),
    .MIC_BIT   (MIC_BIT),
    .OPEN_BUS  (OPEN_BUS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_hit    (rd_hit),
    .wr_hit    (wr_hit),
    .port_idle (port_idle),
    .port_clk  (port_clk),
    .out_latch (out_latch),
    .cpu_wdata (cpu_wdata),
    .rd_data   (rd_data)
);

// File: tb/ctrl_port_if_test.sv
`timescale 1ns/1ps
module ctrl_port_if_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rnw = 1'b1;
    logic        cpu_valid = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic        dma_glitch = 1'b0;
    logic [1:0]  port_data;
    logic        mic_in = 1'b0;
    logic        mic_mode = 1'b0;
    logic [7:0]  rd_data;
    logic [2:0]  out_latch;
    logic        strobe;
    logic [1:0]  port_clk;

    int vectors = 0;
    int misses  = 0;

    always #2 clk = ~clk;

    ctrl_port_if uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_rnw    (cpu_rnw),
        .cpu_valid  (cpu_valid),
        .cpu_wdata  (cpu_wdata),
        .dma_glitch (dma_glitch),
        .port_data  (port_data),
        .mic_in     (mic_in),
        .mic_mode   (mic_mode),
        .rd_data    (rd_data),
        .out_latch  (out_latch),
        .strobe     (strobe),
        .port_clk   (port_clk)
    );

    // Controller model: reload while strobe is high, shift a 1 in on each rising port clock.
    logic [7:0] buttons [2];
    logic [7:0] shreg   [2];
    logic [1:0] prev_clk;

    initial begin
        buttons[0] = '0;
        buttons[1] = '0;
        shreg[0]   = '1;
        shreg[1]   = '1;
        prev_clk   = 2'b11;
    end

    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            prev_clk[i] <= port_clk[i];
            if (strobe)
                shreg[i] <= buttons[i];
            else if (!prev_clk[i] && port_clk[i])
                shreg[i] <= {1'b1, shreg[i][7:1]};
        end
    end

    assign port_data = {shreg[1][0], shreg[0][0]};

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] addr, input logic [7:0] data);
        @(negedge clk);
        cpu_addr  = addr;
        cpu_rnw   = 1'b0;
        cpu_valid = 1'b1;
        cpu_wdata = data;
        @(negedge clk);
        cpu_valid = 1'b0;
        cpu_rnw   = 1'b1;
    endtask

    task automatic strobe_pulse();
        do_write(16'h4016, 8'h01);
        do_write(16'h4016, 8'h00);
    endtask

    // Plain read; returns rd_data once the port is back in idle.
    task automatic do_read(input int port, output logic [7:0] val);
        @(negedge clk);
        cpu_addr  = 16'h4016 + 16'(port);
        cpu_rnw   = 1'b1;
        cpu_valid = 1'b1;
        @(negedge clk);
        cpu_valid = 1'b0;
        @(negedge clk);
        val = rd_data;
    endtask

    task automatic t_reset();
        chk("R8 latch", 8'(out_latch), 8'h00);
        chk("R8 strobe", 8'(strobe), 8'h00);
        chk("R8 port_clk", 8'(port_clk), 8'h03);
        chk("R8 rd_data", rd_data, 8'h40);
    endtask

    task automatic t_latch();
        do_write(16'h4016, 8'hFD);
        chk("R1 latch load", 8'(out_latch), 8'h05);
        chk("R2 strobe high", 8'(strobe), 8'h01);
        do_write(16'h4017, 8'h02);
        chk("R1 other addr ignored", 8'(out_latch), 8'h05);
        do_write(16'h4016, 8'hF8);
        chk("R1 high bits ignored", 8'(out_latch), 8'h00);
        chk("R2 strobe low", 8'(strobe), 8'h00);
    endtask

    task automatic t_serial();
        logic [7:0] v;
        buttons[0] = 8'b1011_0010;
        strobe_pulse();
        // First read: watch the clock shape.
        @(negedge clk);
        cpu_addr = 16'h4016; cpu_valid = 1'b1;
        @(negedge clk);
        cpu_valid = 1'b0;
        chk("R3 port0 low", 8'(port_clk), 8'h02);
        @(negedge clk);
        chk("R3 port0 back high", 8'(port_clk), 8'h03);
        chk("R4 bit0", rd_data, 8'h40 | 8'(buttons[0][0]));
        for (int k = 1; k < 10; k++) begin
            do_read(0, v);
            chk($sformatf("R4 serial bit %0d", k), v,
                8'h40 | ((k < 8) ? 8'(buttons[0][k]) : 8'h01));
        end
    endtask

    task automatic t_strobe_held();
        logic [7:0] v;
        buttons[0] = 8'b0000_0001;
        do_write(16'h4016, 8'h01);
        for (int k = 0; k < 3; k++) begin
            do_read(0, v);
            chk("R2 strobe held repeats first button", v, 8'h41);
        end
        do_write(16'h4016, 8'h00);
        do_read(0, v);
        do_read(0, v);
        chk("R2 after release second button", v, 8'h40);
    endtask

    task automatic t_port1();
        logic [7:0] v;
        buttons[1] = 8'h5A;
        mic_mode = 1'b1;
        mic_in   = 1'b1;
        strobe_pulse();
        @(negedge clk);
        cpu_addr = 16'h4017; cpu_valid = 1'b1;
        @(negedge clk);
        cpu_valid = 1'b0;
        chk("R3 port1 low only", 8'(port_clk), 8'h01);
        @(negedge clk);
        chk("R5 port1 no mic", rd_data, 8'h40 | 8'(buttons[1][0]));
        for (int k = 1; k < 8; k++) begin
            do_read(1, v);
            chk($sformatf("R4 port1 bit %0d", k), v, 8'h40 | 8'(buttons[1][k]));
        end
        mic_mode = 1'b0;
        mic_in   = 1'b0;
    endtask

    task automatic t_mic();
        logic [7:0] v;
        buttons[0] = 8'b0000_0101;
        strobe_pulse();
        mic_mode = 1'b1; mic_in = 1'b1;
        do_read(0, v);
        chk("R5 mic on port0", v, 8'h45);
        mic_mode = 1'b0;
        do_read(0, v);
        chk("R5 mic off in normal mode", v, 8'h40);
        mic_mode = 1'b1; mic_in = 1'b0;
        do_read(0, v);
        chk("R5 mic low", v, 8'h41);
        mic_mode = 1'b0;
    endtask

    task automatic t_glitch();
        logic [7:0] v;
        buttons[0] = 8'b0000_0100;
        strobe_pulse();
        do_read(0, v);
        chk("R6 pre-read first button", v, 8'h40);
        @(negedge clk);
        cpu_addr = 16'h4016; cpu_valid = 1'b1; dma_glitch = 1'b1;
        @(negedge clk);
        cpu_valid = 1'b0; dma_glitch = 1'b0;
        chk("R6 first low", 8'(port_clk[0]), 8'h00);
        @(negedge clk);
        chk("R6 extra high", 8'(port_clk[0]), 8'h01);
        @(negedge clk);
        chk("R6 second low", 8'(port_clk[0]), 8'h00);
        @(negedge clk);
        chk("R6 final high", 8'(port_clk[0]), 8'h01);
        chk("R6 skipped bit returned", rd_data, 8'h41);
        do_read(0, v);
        chk("R6 next read after drop", v, 8'h40);
    endtask

    task automatic t_busy();
        logic [7:0] v;
        buttons[0] = 8'b0000_0001;
        strobe_pulse();
        @(negedge clk);
        cpu_addr = 16'h4016; cpu_valid = 1'b1;
        @(negedge clk);
        chk("R7 accepted read low", 8'(port_clk[0]), 8'h00);
        @(negedge clk);
        cpu_valid = 1'b0;
        chk("R7 busy read no effect high", 8'(port_clk[0]), 8'h01);
        chk("R7 rd_data kept", rd_data, 8'h41);
        @(negedge clk);
        chk("R7 no second pulse", 8'(port_clk[0]), 8'h01);
        do_read(0, v);
        chk("R7 only one shift", v, 8'h40);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_serial();
        t_strobe_held();
        t_port1();
        t_mic();
        t_glitch();
        t_busy();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule